// File: doc/BRIEF.md
# Power-Management Event Enable and Status Block

This block holds the 32-bit event enable register of a chipset power-management controller, together with one sticky status latch per event source. Sixteen general-purpose inputs and a set of internal sources (two USB controllers, two power-management event lines, PCI Express, ring indicate and a battery-low pin) each set a status bit. Each status bit is combined with its enable to drive three registered requests: a system wake, a system control interrupt (SCI) and a system management interrupt (SMI).

The enable fields do not share one reset. Some are cleared only by the resume-well reset. Some are cleared only by the RTC-well reset, so they survive a full power loss. The rest are also cleared by a software-initiated hard reset. The sources are routed differently. Some sources can only wake the system. Some can only raise an SCI. Two sources raise either an SCI or an SMI, chosen by a mode input. A low battery level blocks every wake request.

Top module: `pm_evt_en_top`

## Requirements
- R1: A write with `wr_en` high loads bits 31:16 and 14:8 of `wr_data` into the enable register, and `rd_data` shows the new value after the next clock edge.
- R2: Bits 15 and 7:0 of `rd_data` and `sts_rd` always read 0, and writes or events cannot set them.
- R3: The GPI enables (bit 16+n for input n, n = 0..15) are cleared only by `rsm_rst`. `hard_rst` and `rtc_rst` leave them unchanged.
- R4: The PME_B0 enable (bit 13) and the ring-indicate enable (bit 8) are cleared only by `rtc_rst` or by writing 0. `rsm_rst` and `hard_rst` leave them unchanged.
- R5: The enables at bits 14, 12, 11, 10 and 9 are cleared by either `rsm_rst` or `hard_rst`.
- R6: Status bits sit at the same positions as their enables: GPI n at 16+n, USB4 at 14, PME_B0 at 13, USB3 at 12, PME at 11, battery-low at 10, PCI Express at 9, ring indicate at 8. An event pulse sets its bit. A 1 in `sts_clr` clears the bit. An event and a clear in the same cycle leave the bit set. `rsm_rst` clears every status bit.
- R7: `batlow_n` passes through a two-flop synchroniser. Only a high-to-low transition sets status bit 10, on the third rising clock edge after the input falls.
- R8: `wake_req` is, one cycle later, the OR of status AND enable over bits 31:16, 14, 13, 12, 11 and 8. It is forced to 0 while the synchronised `batlow_n` is low.
- R9: `sci_req` is, one cycle later, the OR of status AND enable over bits 31:16, 11 and 9, plus bits 13 and 10 when `sci_en` is 1. USB3 and USB4 never raise it.
- R10: `smi_req` is, one cycle later, the OR of status AND enable over bits 13 and 10 when `sci_en` is 0, and 0 otherwise.
- R11: While `rsm_rst` is high, `wake_req`, `sci_req`, `smi_req` and all status bits go to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst | input | 1 | Resume-well synchronous reset, active high |
| rtc_rst | input | 1 | RTC-well synchronous reset, active high |
| hard_rst | input | 1 | Software hard reset, active high |
| wr_en | input | 1 | Enable register write strobe |
| wr_data | input | 32 | Enable register write value |
| rd_data | output | 32 | Current enable register value |
| sci_en | input | 1 | 1 routes bits 13 and 10 to SCI, 0 routes them to SMI |
| gpi_evt | input | 16 | GPI event pulses, bit n for input n |
| usb4_evt | input | 1 | USB controller 4 wake event pulse |
| pme_b0_evt | input | 1 | Internal PME event pulse |
| usb3_evt | input | 1 | USB controller 3 wake event pulse |
| pme_evt | input | 1 | External PME event pulse |
| pcie_evt | input | 1 | PCI Express wake/PME event pulse |
| ri_evt | input | 1 | Ring-indicate event pulse |
| batlow_n | input | 1 | Asynchronous battery-low level, active low |
| sts_clr | input | 32 | Write-one-to-clear pulses for the status bits |
| sts_rd | output | 32 | Current status bits |
| wake_req | output | 1 | Registered wake request |
| sci_req | output | 1 | Registered SCI request |
| smi_req | output | 1 | Registered SMI request |

## Verification
The checker asserts on every cycle that reserved bits stay 0, that a status bit survives unless cleared, and that each request follows a prior status and enable term that its route allows. It also asserts that SMI only follows a cycle with `sci_en` low, and that a hard reset leaves the GPI, PME_B0 and ring-indicate enables untouched. The bench's scenarios cover what a one-cycle property cannot show: the three-edge latency of the battery-low path, wake blocking while the battery is low and the release that follows, the set-wins-over-clear case, and the exact survivor value after each kind of reset. A cycle-by-cycle reference model, driven with random traffic, checks every output on every clock.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int REG_W   = 32;
    localparam int GPI_N   = 16;
    localparam int GPI_LSB = 16;

    localparam int B_USB4   = 14;
    localparam int B_PMEB0  = 13;
    localparam int B_USB3   = 12;
    localparam int B_PME    = 11;
    localparam int B_BATLOW = 10;
    localparam int B_PCIE   = 9;
    localparam int B_RI     = 8;

    // reset-domain groups of the enable register
    localparam logic [REG_W-1:0] GPI_MASK  = 32'hFFFF_0000;
    localparam logic [REG_W-1:0] RTC_MASK  = (32'h1 << B_PMEB0) | (32'h1 << B_RI);
    localparam logic [REG_W-1:0] HARD_MASK = (32'h1 << B_USB4) | (32'h1 << B_USB3) |
                                             (32'h1 << B_PME)  | (32'h1 << B_BATLOW) |
                                             (32'h1 << B_PCIE);
    localparam logic [REG_W-1:0] IMPL_MASK = GPI_MASK | RTC_MASK | HARD_MASK;

    // output routing groups
    localparam logic [REG_W-1:0] WAKE_MASK = GPI_MASK | (32'h1 << B_USB4) | (32'h1 << B_PMEB0) |
                                             (32'h1 << B_USB3) | (32'h1 << B_PME) | (32'h1 << B_RI);
    localparam logic [REG_W-1:0] SCI_FIXED = GPI_MASK | (32'h1 << B_PME) | (32'h1 << B_PCIE);
    localparam logic [REG_W-1:0] SEL_MASK  = (32'h1 << B_PMEB0) | (32'h1 << B_BATLOW);

    typedef struct packed {
        logic wake;
        logic sci;
        logic smi;
    } pm_req_t;

    function automatic logic [REG_W-1:0] sci_route(input logic sci_mode);
        return SCI_FIXED | (sci_mode ? SEL_MASK : '0);
    endfunction

    function automatic logic [REG_W-1:0] smi_route(input logic sci_mode);
        return sci_mode ? '0 : SEL_MASK;
    endfunction

endpackage

// File: rtl/pm_evt_enreg.sv
module pm_evt_enreg
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rsm_rst,
    input  logic             rtc_rst,
    input  logic             hard_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] en_q
);

    logic [REG_W-1:0] clr_vec;

    // each bit picks the reset that owns its field
    for (genvar i = 0; i < REG_W; i++) begin : g_dom
        if (RTC_MASK[i]) begin : g_rtc
            assign clr_vec[i] = rtc_rst;
        end else if (GPI_MASK[i]) begin : g_rsm
            assign clr_vec[i] = rsm_rst;
        end else begin : g_hard
            assign clr_vec[i] = rsm_rst | hard_rst;
        end
    end

    always_ff @(posedge clk) begin
        en_q <= ((wr_en ? wr_data : en_q) & ~clr_vec) & IMPL_MASK;
    end

endmodule

// File: rtl/pm_evt_sts.sv
module pm_evt_sts
    import pm_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rsm_rst,
    input  logic [REG_W-1:0] evt_raw,
    input  logic             batlow_n,
    input  logic [REG_W-1:0] clr,
    output logic [REG_W-1:0] sts_q,
    output logic             batlow_ok
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic                   bl_fall;
    logic [REG_W-1:0]       set_vec;

    always_ff @(posedge clk) begin
        if (rsm_rst) begin
            sync_q <= '1;
            hist_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], batlow_n};
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign batlow_ok = sync_q[SYNC_STAGES-1];
    assign bl_fall   = hist_q & ~batlow_ok;
    assign set_vec   = evt_raw | (REG_W'(bl_fall) << B_BATLOW);

    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rsm_rst) sts_q <= '0;
        else         sts_q <= ((sts_q & ~clr) | set_vec) & IMPL_MASK;
    end

endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rsm_rst,
    input  logic [REG_W-1:0] sts,
    input  logic [REG_W-1:0] en,
    input  logic             sci_en,
    input  logic             batlow_ok,
    output pm_req_t          req_q
);

    logic [REG_W-1:0] armed;
    pm_req_t          req_d;

    always_comb begin
        armed      = sts & en;
        req_d.wake = (|(armed & WAKE_MASK)) & batlow_ok;
        req_d.sci  = |(armed & sci_route(sci_en));
        req_d.smi  = |(armed & smi_route(sci_en));
    end

    always_ff @(posedge clk) begin
        if (rsm_rst) req_q <= '0;
        else         req_q <= req_d;
    end

endmodule

// File: rtl/pm_evt_en_top.sv
module pm_evt_en_top
    import pm_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rsm_rst,
    input  logic        rtc_rst,
    input  logic        hard_rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        sci_en,
    input  logic [15:0] gpi_evt,
    input  logic        usb4_evt,
    input  logic        pme_b0_evt,
    input  logic        usb3_evt,
    input  logic        pme_evt,
    input  logic        pcie_evt,
    input  logic        ri_evt,
    input  logic        batlow_n,
    input  logic [31:0] sts_clr,
    output logic [31:0] sts_rd,
    output logic        wake_req,
    output logic        sci_req,
    output logic        smi_req
);

    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] evt_vec;
    logic             batlow_ok;
    pm_req_t          req_q;

    always_comb begin
        evt_vec                           = '0;
        evt_vec[GPI_LSB +: GPI_N]         = gpi_evt;
        evt_vec[B_USB4]                   = usb4_evt;
        evt_vec[B_PMEB0]                  = pme_b0_evt;
        evt_vec[B_USB3]                   = usb3_evt;
        evt_vec[B_PME]                    = pme_evt;
        evt_vec[B_PCIE]                   = pcie_evt;
        evt_vec[B_RI]                     = ri_evt;
    end

    pm_evt_enreg u_enreg (
        .clk      (clk),
        .rsm_rst  (rsm_rst),
        .rtc_rst  (rtc_rst),
        .hard_rst (hard_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .en_q     (en_q)
    );

    pm_evt_sts #(.SYNC_STAGES(SYNC_STAGES)) u_sts (
        .clk       (clk),
        .rsm_rst   (rsm_rst),
        .evt_raw   (evt_vec),
        .batlow_n  (batlow_n),
        .clr       (sts_clr),
        .sts_q     (sts_q),
        .batlow_ok (batlow_ok)
    );

    pm_evt_route u_route (
        .clk       (clk),
        .rsm_rst   (rsm_rst),
        .sts       (sts_q),
        .en        (en_q),
        .sci_en    (sci_en),
        .batlow_ok (batlow_ok),
        .req_q     (req_q)
    );

    assign rd_data  = en_q;
    assign sts_rd   = sts_q;
    assign wake_req = req_q.wake;
    assign sci_req  = req_q.sci;
    assign smi_req  = req_q.smi;

endmodule

// File: rtl/pm_evt_en_chk.sv
module pm_evt_en_chk
    import pm_evt_pkg::*;
(
    input logic        clk,
    input logic        rsm_rst,
    input logic        rtc_rst,
    input logic        hard_rst,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        sci_en,
    input logic [31:0] sts_clr,
    input logic [31:0] sts_rd,
    input logic        wake_req,
    input logic        sci_req,
    input logic        smi_req
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rsm_rst)
        ((rd_data | sts_rd) & ~IMPL_MASK) == '0); // R2

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rsm_rst)
        1'b1 |=> ((sts_rd & $past(sts_rd & ~sts_clr)) == $past(sts_rd & ~sts_clr))); // R6

    AST_WAKE_SRC: assert property (@(posedge clk) disable iff (rsm_rst)
        wake_req |-> $past(|(sts_rd & rd_data & WAKE_MASK))); // R8

    AST_SCI_SRC: assert property (@(posedge clk) disable iff (rsm_rst)
        sci_req |-> $past(|(sts_rd & rd_data & sci_route(sci_en)))); // R9

    AST_SMI_MODE: assert property (@(posedge clk) disable iff (rsm_rst)
        smi_req |-> $past(!sci_en && |(sts_rd & rd_data & SEL_MASK))); // R10

    AST_GPI_KEEP: assert property (@(posedge clk) disable iff (rsm_rst)
        (hard_rst && !wr_en) |=> ((rd_data & GPI_MASK) == $past(rd_data & GPI_MASK))); // R3

    AST_RTC_KEEP: assert property (@(posedge clk) disable iff (rsm_rst)
        (hard_rst && !rtc_rst && !wr_en) |=> ((rd_data & RTC_MASK) == $past(rd_data & RTC_MASK))); // R4

endmodule

bind pm_evt_en_top pm_evt_en_chk u_chk (
    .clk      (clk),
    .rsm_rst  (rsm_rst),
    .rtc_rst  (rtc_rst),
    .hard_rst (hard_rst),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .sci_en   (sci_en),
    .sts_clr  (sts_clr),
    .sts_rd   (sts_rd),
    .wake_req (wake_req),
    .sci_req  (sci_req),
    .smi_req  (smi_req)
);

// File: tb/pm_evt_en_top_tb.sv
module pm_evt_en_top_tb;

    // bench-side constants taken from the bit positions in the requirements
    localparam logic [31:0] T_GPI  = 32'hFFFF_0000;
    localparam logic [31:0] T_RTC  = (32'h1 << 13) | (32'h1 << 8);
    localparam logic [31:0] T_HARD = (32'h1 << 14) | (32'h1 << 12) | (32'h1 << 11) |
                                     (32'h1 << 10) | (32'h1 << 9);
    localparam logic [31:0] T_RW   = T_GPI | T_RTC | T_HARD;
    localparam logic [31:0] T_WAKE = T_GPI | (32'h1 << 14) | (32'h1 << 13) | (32'h1 << 12) |
                                     (32'h1 << 11) | (32'h1 << 8);
    localparam logic [31:0] T_SCI  = T_GPI | (32'h1 << 11) | (32'h1 << 9);
    localparam logic [31:0] T_SEL  = (32'h1 << 13) | (32'h1 << 10);

    logic        clk = 1'b0;
    logic        rsm_rst = 1'b1, rtc_rst = 1'b1, hard_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sci_en = 1'b1;
    logic [15:0] gpi_evt = '0;
    logic        usb4_evt = 1'b0, pme_b0_evt = 1'b0, usb3_evt = 1'b0;
    logic        pme_evt = 1'b0, pcie_evt = 1'b0, ri_evt = 1'b0;
    logic        batlow_n = 1'b1;
    logic [31:0] sts_clr = '0;
    logic [31:0] sts_rd;
    logic        wake_req, sci_req, smi_req;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pm_evt_en_top u_dut (
        .clk(clk), .rsm_rst(rsm_rst), .rtc_rst(rtc_rst), .hard_rst(hard_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sci_en(sci_en),
        .gpi_evt(gpi_evt), .usb4_evt(usb4_evt), .pme_b0_evt(pme_b0_evt),
        .usb3_evt(usb3_evt), .pme_evt(pme_evt), .pcie_evt(pcie_evt), .ri_evt(ri_evt),
        .batlow_n(batlow_n), .sts_clr(sts_clr), .sts_rd(sts_rd),
        .wake_req(wake_req), .sci_req(sci_req), .smi_req(smi_req)
    );

    // reference model state
    logic [31:0] m_en = '0, m_sts = '0;
    logic        m_wake = 1'b0, m_sci = 1'b0, m_smi = 1'b0;
    logic        m_b1 = 1'b1, m_b2 = 1'b1, m_b3 = 1'b1;

    always @(posedge clk) begin
        logic [31:0] evt, en_n, sts_n;
        logic w, s, m, fall;
        fall = m_b3 & ~m_b2;
        w = (|(m_sts & m_en & T_WAKE)) & m_b2;
        s = |(m_sts & m_en & (T_SCI | (sci_en ? T_SEL : 32'h0)));
        m = |(m_sts & m_en & (sci_en ? 32'h0 : T_SEL));
        evt = {gpi_evt, 1'b0, usb4_evt, pme_b0_evt, usb3_evt, pme_evt, fall, pcie_evt, ri_evt, 8'h0};
        sts_n = (m_sts & ~sts_clr) | evt;
        en_n = wr_en ? (wr_data & T_RW) : m_en;
        if (rtc_rst)  en_n = en_n & ~T_RTC;
        if (hard_rst) en_n = en_n & ~T_HARD;
        if (rsm_rst) begin
            en_n = en_n & ~(T_GPI | T_HARD);
            sts_n = '0; w = 1'b0; s = 1'b0; m = 1'b0;
            m_b1 = 1'b1; m_b2 = 1'b1; m_b3 = 1'b1;
        end else begin
            m_b3 = m_b2; m_b2 = m_b1; m_b1 = batlow_n;
        end
        m_en = en_n; m_sts = sts_n;
        m_wake = w; m_sci = s; m_smi = m;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(rd_data === m_en,   "R1 model rd_data", rd_data, m_en);
            chk(sts_rd  === m_sts,  "R6 model sts_rd",  sts_rd,  m_sts);
            chk(wake_req === m_wake, "R8 model wake_req", 32'(wake_req), 32'(m_wake));
            chk(sci_req  === m_sci,  "R9 model sci_req",  32'(sci_req),  32'(m_sci));
            chk(smi_req  === m_smi,  "R10 model smi_req", 32'(smi_req),  32'(m_smi));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v; step(1); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(2);
        rsm_rst = 1'b0; rtc_rst = 1'b0; hard_rst = 1'b0;
        cmp_on = 1'b1;
        step(1);
        chk(rd_data == 32'h0, "R3 enables after reset", rd_data, 32'h0);
        chk(sts_rd == 32'h0, "R11 status after reset", sts_rd, 32'h0);
        chk({wake_req, sci_req, smi_req} == 3'b000, "R11 requests after reset",
            32'({wake_req, sci_req, smi_req}), 32'h0);

        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'hFFFF_7F00, "R1 write all ones", rd_data, 32'hFFFF_7F00);
        chk((rd_data & 32'h0000_80FF) == 0, "R2 reserved bits", rd_data, 32'h0);

        hard_rst = 1'b1; step(1); hard_rst = 1'b0;
        chk(rd_data == 32'hFFFF_2100, "R5 hard reset clears its group", rd_data, 32'hFFFF_2100);
        chk((rd_data & T_GPI) == T_GPI, "R3 GPI survives hard reset", rd_data, T_GPI);

        rsm_rst = 1'b1; step(1); rsm_rst = 1'b0;
        chk(rd_data == 32'h0000_2100, "R4 RTC fields survive resume reset", rd_data, 32'h0000_2100);

        rtc_rst = 1'b1; step(1); rtc_rst = 1'b0;
        chk(rd_data == 32'h0, "R4 RTC reset clears bits 13 and 8", rd_data, 32'h0);

        wr(32'h0000_80FF);
        chk(rd_data == 32'h0, "R2 write to reserved ignored", rd_data, 32'h0);

        // USB3 wakes but does not raise SCI
        wr(32'h0000_1000);
        usb3_evt = 1'b1; step(1); usb3_evt = 1'b0;
        chk(sts_rd == 32'h0000_1000, "R6 USB3 status set", sts_rd, 32'h0000_1000);
        step(1);
        chk(wake_req == 1'b1, "R8 USB3 wake", 32'(wake_req), 32'h1);
        chk(sci_req == 1'b0, "R9 USB3 no SCI", 32'(sci_req), 32'h0);
        sts_clr = 32'h0000_1000; step(1); sts_clr = '0;
        step(1);
        chk(wake_req == 1'b0, "R8 wake drops after clear", 32'(wake_req), 32'h0);

        // PCI Express raises SCI, no wake
        wr(32'h0000_0200);
        pcie_evt = 1'b1; step(1); pcie_evt = 1'b0;
        step(1);
        chk(sci_req == 1'b1, "R9 PCIe SCI", 32'(sci_req), 32'h1);
        chk(wake_req == 1'b0, "R8 PCIe no wake", 32'(wake_req), 32'h0);
        sts_clr = 32'h0000_0200; step(1); sts_clr = '0;

        // battery-low falling edge, SMI mode
        sci_en = 1'b0;
        wr(32'h0000_0400);
        batlow_n = 1'b0;
        step(2);
        chk(sts_rd[10] == 1'b0, "R7 not set before third edge", 32'(sts_rd[10]), 32'h0);
        step(1);
        chk(sts_rd[10] == 1'b1, "R7 set on third edge", 32'(sts_rd[10]), 32'h1);
        step(1);
        chk(smi_req == 1'b1, "R10 battery-low SMI", 32'(smi_req), 32'h1);
        chk(sci_req == 1'b0, "R10 no SCI in SMI mode", 32'(sci_req), 32'h0);
        sci_en = 1'b1; step(1);
        chk(sci_req == 1'b1 && smi_req == 1'b0, "R9 battery-low SCI mode",
            32'({sci_req, smi_req}), 32'h2);

        // wake is blocked while battery low
        sts_clr = 32'h0000_0400; step(1); sts_clr = '0;
        wr(32'h0001_0000);
        gpi_evt = 16'h0001; step(1); gpi_evt = '0;
        step(2);
        chk(wake_req == 1'b0, "R8 wake blocked by battery low", 32'(wake_req), 32'h0);
        chk(sci_req == 1'b1, "R9 GPI0 SCI", 32'(sci_req), 32'h1);
        batlow_n = 1'b1;
        step(3);
        chk(wake_req == 1'b1, "R8 wake after battery recovers", 32'(wake_req), 32'h1);
        chk(sts_rd[10] == 1'b0, "R7 rising edge does not set", 32'(sts_rd[10]), 32'h0);

        // set wins over simultaneous clear
        sts_clr = 32'h0001_0000; gpi_evt = 16'h0001; step(1);
        sts_clr = '0; gpi_evt = '0;
        chk(sts_rd[16] == 1'b1, "R6 set beats clear", 32'(sts_rd[16]), 32'h1);
        step(2);
        chk(sts_rd[16] == 1'b1, "R6 sticky hold", 32'(sts_rd[16]), 32'h1);
        sts_clr = 32'h0001_0000; step(1); sts_clr = '0;
        chk(sts_rd[16] == 1'b0, "R6 clear", 32'(sts_rd[16]), 32'h0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            rsm_rst  = ($urandom_range(0, 399) == 0);
            rtc_rst  = ($urandom_range(0, 299) == 0);
            hard_rst = ($urandom_range(0, 199) == 0);
            wr_en    = ($urandom_range(0, 9) == 0);
            wr_data  = $urandom;
            gpi_evt  = 16'($urandom & $urandom & $urandom);
            usb4_evt   = ($urandom_range(0, 7) == 0);
            pme_b0_evt = ($urandom_range(0, 7) == 0);
            usb3_evt   = ($urandom_range(0, 7) == 0);
            pme_evt    = ($urandom_range(0, 7) == 0);
            pcie_evt   = ($urandom_range(0, 7) == 0);
            ri_evt     = ($urandom_range(0, 7) == 0);
            sts_clr  = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
            if ($urandom_range(0, 29) == 0) batlow_n = ~batlow_n;
            if ($urandom_range(0, 49) == 0) sci_en = ~sci_en;
            step(1);
        end
        finish_run();
    end

endmodule